// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This block collects up to four banks of 32 level-sensitive interrupt lines and drives two requests to a processor: a normal request and a fast request. Each line is pending while its registered input level is high or while its software-set bit is set. A line counts for arbitration only when its mask bit is clear. A per-line route bit sends it to either the fast or the normal channel. Each channel picks the unmasked pending line with the smallest priority value, and when two lines tie, the lower line number wins.

Each channel fires once and then waits for software. When an armed channel sees a candidate line while the global mask is off, it raises its output one cycle later. At the same time it latches the winning line number into its code register and disarms. The output and the code then hold, even if the source goes away, until software writes the re-arm bit for that channel in the control register. That write drops the output at once, and the channel evaluates again on the next cycle. All registers are 32 bits wide and sit behind a simple word port: a write strobe and a combinational read.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask bit is 1 and the software bits, route bits and priorities are 0. Both outputs are low. The revision register at 0x00 reads 0x21, and the status register at 0x14 reads 1.
- R2: The per-bank window of bank b starts at 0x80+0x20*b. Offset +0x0 reads the registered input levels. Pending is the input level OR the software bit. Offset +0x18 reads pending & ~mask & ~route, and offset +0x1C reads pending & ~mask & route.
- R3: Offset +0x4 writes and reads the whole mask. Writing to +0x8 clears the mask bits given as ones, and writing to +0xC sets them. Both aliases read 0, and each bank has its own mask.
- R4: Writing to +0x10 ORs the value into the software bits, which read back at +0x10. Writing to +0x14 clears the software bits given as ones. A line whose input is still high stays pending after its software bit is cleared.
- R5: Line n has its configuration word at 0x100+4*n, which gives bank (offset-0x100)>>7 and line (offset&0x7F)>>2. Bits [7:2] hold a 6-bit priority and bit 0 is the route (1 means fast). Bit 1 is not stored. Addresses past the last bank read 0 and ignore writes.
- R6: Among the candidate lines of a channel, the smallest priority value wins, and a tie goes to the lowest line number. The latched line number, 32*bank+line, reads at 0x40 for the normal channel and at 0x44 for the fast channel.
- R7: An armed channel with a candidate raises its output on the second clock edge after the input rises. The output and the code then hold until that channel is re-armed, even after the source goes away.
- R8: In the control register at 0x48, writing bit 0 re-arms the normal channel and writing bit 1 re-arms the fast channel. The output is low after the write edge, and it rises again one edge later if a candidate is still present.
- R9: Control bit 2 is a global mask that reads back at bit 2. While it is set, neither output rises. Clearing it lets an armed channel fire.
- R10: Register 0x10 stores an autoidle flag in bit 0. Writing 1 to its bit 1 returns every register to its reset value. Register 0x4C stores bit 0 and register 0x50 stores bits [1:0].
- R11: Writes to the revision, status, code, raw-input and pending-view registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Byte address of the register word |
| reg_we_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_lines_i | input | 32*NBANKS | Level interrupt inputs, line n on bit n |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A one-hot sweep raises each of the 64 lines of a two-bank build in turn, with the route alternating between lines. This tells apart a wrong line number, a wrong route and a wrong bank offset, and it also shows that the output holds after the line drops. Multi-line patterns are then run under two priority maps. One map has only distinct values, which separates true minimum search from positional order. The other has many ties, which exposes a wrong tie-break direction. Separate sequences cover the mask and software aliases, the interaction between software clear and an active input, the gating by the global mask, re-arm while the line is still high, and soft reset.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    localparam int REG_AW    = 12;
    localparam int REG_DW    = 32;
    localparam int BANK_W    = 32;

    // global registers
    localparam logic [REG_AW-1:0] A_REV     = 12'h000;
    localparam logic [REG_AW-1:0] A_SYSCFG  = 12'h010;
    localparam logic [REG_AW-1:0] A_STATUS  = 12'h014;
    localparam logic [REG_AW-1:0] A_CODE_N  = 12'h040;
    localparam logic [REG_AW-1:0] A_CODE_F  = 12'h044;
    localparam logic [REG_AW-1:0] A_CTRL    = 12'h048;
    localparam logic [REG_AW-1:0] A_PROT    = 12'h04C;
    localparam logic [REG_AW-1:0] A_IDLE    = 12'h050;
    localparam logic [REG_AW-1:0] A_CFG_BASE = 12'h100;

    // word index inside a bank window
    typedef enum logic [2:0] {
        BR_RAW     = 3'd0,
        BR_MASK    = 3'd1,
        BR_MASK_CL = 3'd2,
        BR_MASK_ST = 3'd3,
        BR_SW_SET  = 3'd4,
        BR_SW_CLR  = 3'd5,
        BR_PEND_N  = 3'd6,
        BR_PEND_F  = 3'd7
    } bank_reg_e;

    localparam int CH_NORM = 0;
    localparam int CH_FAST = 1;
    localparam int NCH     = 2;

endpackage

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb #(
    parameter int NLINES = 64,
    parameter int PRIO_W = 6,
    parameter int IDW    = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]             req_i,
    input  logic [NLINES-1:0][PRIO_W-1:0] prio_i,
    output logic                          any_o,
    output logic [IDW-1:0]                win_o
);

    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDW-1:0]    idx;

    // ascending scan with strict compare: equal priority keeps the lower line
    always_comb begin
        found = 1'b0;
        best  = '1;
        idx   = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (req_i[i] && (!found || (prio_i[i] < best))) begin
                found = 1'b1;
                best  = prio_i[i];
                idx   = IDW'(i);
            end
        end
        any_o = found;
        win_o = idx;
    end

endmodule

// File: rtl/lvl_intc_chan.sv
module lvl_intc_chan #(
    parameter int IDW = 6
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           soft_rst_i,
    input  logic           rearm_i,
    input  logic           en_i,
    input  logic           any_i,
    input  logic [IDW-1:0] win_i,
    output logic           out_o,
    output logic [IDW-1:0] code_o
);

    typedef struct packed {
        logic           armed;
        logic           out;
        logic [IDW-1:0] code;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (soft_rst_i) begin
            ch_d.armed = 1'b1;
            ch_d.out   = 1'b0;
            ch_d.code  = '0;
        end else if (rearm_i) begin
            ch_d.armed = 1'b1;
            ch_d.out   = 1'b0;
        end else if (ch_q.armed && en_i && any_i) begin
            ch_d.armed = 1'b0;
            ch_d.out   = 1'b1;
            ch_d.code  = win_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q.armed <= 1'b1;
            ch_q.out   <= 1'b0;
            ch_q.code  <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign out_o  = ch_q.out;
    assign code_o = ch_q.code;

    AST_OUT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_q.out && !rearm_i && !soft_rst_i |=> ch_q.out); // R7

    AST_CODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_q.out && !rearm_i && !soft_rst_i |=> $stable(ch_q.code)); // R7

    AST_REARM_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rearm_i |=> !ch_q.out); // R8

    AST_FIRE_UNBLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ch_q.out) |-> ($past(en_i) && $past(any_i))); // R9

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int          NBANKS   = 4,
    parameter int          PRIO_W   = 6,
    parameter logic [31:0] REVISION = 32'h0000_0021
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [REG_AW-1:0]          reg_addr_i,
    input  logic                       reg_we_i,
    input  logic [REG_DW-1:0]          reg_wdata_i,
    output logic [REG_DW-1:0]          reg_rdata_o,
    input  logic [BANK_W*NBANKS-1:0]   irq_lines_i,
    output logic                       irq_o,
    output logic                       fiq_o
);

    localparam int NLINES   = BANK_W * NBANKS;
    localparam int IDW      = $clog2(NLINES);
    localparam int CFG_SPAN = NLINES * 4;

    typedef struct packed {
        logic [NLINES-1:0]             lines;
        logic [NLINES-1:0]             mask;
        logic [NLINES-1:0]             swi;
        logic [NLINES-1:0]             route;
        logic [NLINES-1:0][PRIO_W-1:0] prio;
        logic                          gmask;
        logic                          autoidle;
        logic                          prot;
        logic [1:0]                    idle;
    } st_t;

    function automatic st_t reset_state();
        st_t s;
        s.lines    = '0;
        s.mask     = '1;
        s.swi      = '0;
        s.route    = '0;
        s.prio     = '0;
        s.gmask    = 1'b0;
        s.autoidle = 1'b0;
        s.prot     = 1'b0;
        s.idle     = 2'b00;
        return s;
    endfunction

    st_t st_d, st_q;

    // address decode
    logic [1:0]        bank_sel;
    bank_reg_e         bank_reg;
    logic              bank_hit;
    logic [REG_AW-1:0] cfg_off;
    logic              cfg_hit;
    logic [IDW-1:0]    cfg_line;

    assign bank_sel = reg_addr_i[6:5];
    assign bank_reg = bank_reg_e'(reg_addr_i[4:2]);
    assign bank_hit = (reg_addr_i[REG_AW-1:7] == 5'b00001) && (int'(bank_sel) < NBANKS);
    assign cfg_off  = reg_addr_i - A_CFG_BASE;
    assign cfg_hit  = (reg_addr_i >= A_CFG_BASE) && (int'(cfg_off) < CFG_SPAN);
    assign cfg_line = cfg_off[IDW+1:2];

    // candidate lines per channel
    logic [NLINES-1:0]          live;
    logic [NCH-1:0][NLINES-1:0] ch_req;
    logic [NCH-1:0]             ch_any;
    logic [NCH-1:0][IDW-1:0]    ch_win;
    logic [NCH-1:0]             ch_out;
    logic [NCH-1:0][IDW-1:0]    ch_code;
    logic [NCH-1:0]             rearm;
    logic                       soft_rst;

    assign live             = (st_q.lines | st_q.swi) & ~st_q.mask;
    assign ch_req[CH_NORM]  = live & ~st_q.route;
    assign ch_req[CH_FAST]  = live & st_q.route;

    assign rearm    = (reg_we_i && reg_addr_i == A_CTRL) ? reg_wdata_i[1:0] : 2'b00;
    assign soft_rst = reg_we_i && (reg_addr_i == A_SYSCFG) && reg_wdata_i[1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvl_intc_arb #(.NLINES(NLINES), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
            .req_i  (ch_req[c]),
            .prio_i (st_q.prio),
            .any_o  (ch_any[c]),
            .win_o  (ch_win[c])
        );
        lvl_intc_chan #(.IDW(IDW)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst),
            .rearm_i    (rearm[c]),
            .en_i       (!st_q.gmask),
            .any_i      (ch_any[c]),
            .win_i      (ch_win[c]),
            .out_o      (ch_out[c]),
            .code_o     (ch_code[c])
        );
    end

    assign irq_o = ch_out[CH_NORM];
    assign fiq_o = ch_out[CH_FAST];

    // next state
    always_comb begin
        st_d       = st_q;
        st_d.lines = irq_lines_i;
        if (reg_we_i) begin
            case (reg_addr_i)
                A_SYSCFG: st_d.autoidle = reg_wdata_i[0];
                A_CTRL:   st_d.gmask    = reg_wdata_i[2];
                A_PROT:   st_d.prot     = reg_wdata_i[0];
                A_IDLE:   st_d.idle     = reg_wdata_i[1:0];
                default: ;
            endcase
            if (bank_hit) begin
                for (int b = 0; b < NBANKS; b++) begin
                    if (int'(bank_sel) == b) begin
                        case (bank_reg)
                            BR_MASK:    st_d.mask[b*BANK_W +: BANK_W] = reg_wdata_i;
                            BR_MASK_CL: st_d.mask[b*BANK_W +: BANK_W] =
                                            st_q.mask[b*BANK_W +: BANK_W] & ~reg_wdata_i;
                            BR_MASK_ST: st_d.mask[b*BANK_W +: BANK_W] =
                                            st_q.mask[b*BANK_W +: BANK_W] | reg_wdata_i;
                            BR_SW_SET:  st_d.swi[b*BANK_W +: BANK_W] =
                                            st_q.swi[b*BANK_W +: BANK_W] | reg_wdata_i;
                            BR_SW_CLR:  st_d.swi[b*BANK_W +: BANK_W] =
                                            st_q.swi[b*BANK_W +: BANK_W] & ~reg_wdata_i;
                            default: ;
                        endcase
                    end
                end
            end
            if (cfg_hit) begin
                for (int i = 0; i < NLINES; i++) begin
                    if (cfg_line == IDW'(i)) begin
                        st_d.prio[i]  = reg_wdata_i[PRIO_W+1:2];
                        st_d.route[i] = reg_wdata_i[0];
                    end
                end
            end
        end
        if (soft_rst) begin
            st_d       = reset_state();
            st_d.lines = irq_lines_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= reset_state();
        else         st_q <= st_d;
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_REV:    reg_rdata_o = REVISION;
            A_SYSCFG: reg_rdata_o[0] = st_q.autoidle;
            A_STATUS: reg_rdata_o = 32'd1;
            A_CODE_N: reg_rdata_o = 32'(ch_code[CH_NORM]);
            A_CODE_F: reg_rdata_o = 32'(ch_code[CH_FAST]);
            A_CTRL:   reg_rdata_o[2] = st_q.gmask;
            A_PROT:   reg_rdata_o[0] = st_q.prot;
            A_IDLE:   reg_rdata_o[1:0] = st_q.idle;
            default: ;
        endcase
        if (bank_hit) begin
            for (int b = 0; b < NBANKS; b++) begin
                if (int'(bank_sel) == b) begin
                    case (bank_reg)
                        BR_RAW:    reg_rdata_o = st_q.lines[b*BANK_W +: BANK_W];
                        BR_MASK:   reg_rdata_o = st_q.mask[b*BANK_W +: BANK_W];
                        BR_SW_SET: reg_rdata_o = st_q.swi[b*BANK_W +: BANK_W];
                        BR_PEND_N: reg_rdata_o = ch_req[CH_NORM][b*BANK_W +: BANK_W];
                        BR_PEND_F: reg_rdata_o = ch_req[CH_FAST][b*BANK_W +: BANK_W];
                        default:   reg_rdata_o = '0;
                    endcase
                end
            end
        end
        if (cfg_hit) begin
            for (int i = 0; i < NLINES; i++) begin
                if (cfg_line == IDW'(i)) begin
                    reg_rdata_o[PRIO_W+1:2] = st_q.prio[i];
                    reg_rdata_o[0]          = st_q.route[i];
                end
            end
        end
    end

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst |=> ((&st_q.mask) && (st_q.swi == '0) && !irq_o && !fiq_o)); // R10

    AST_RO_RAW_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && bank_hit && bank_reg == BR_PEND_N) |=> $stable(st_q.mask)); // R11

endmodule

// File: tb/lvl_intc_test.sv
module lvl_intc_test;

    localparam int NB = 2;
    localparam int NL = 32 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] lines = '0;
    logic          irq, fiq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvl_intc #(.NBANKS(NB)) uut (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_lines_i(lines),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic int prio_map(input int i, input int sel);
        if (sel == 0) return (i * 37 + 11) % 64;
        return (i * 5) % 8;
    endfunction

    function automatic int exp_winner(input logic [NL-1:0] pat, input int sel);
        int best = 99;
        int w = 0;
        for (int i = 0; i < NL; i++)
            if (pat[i] && prio_map(i, sel) < best) begin
                best = prio_map(i, sel);
                w = i;
            end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NL-1:0] pats [6];
        pats[0] = 64'h0000_0000_0000_00F0;
        pats[1] = 64'h8000_0000_0000_0001;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'h0123_4567_89AB_CDEF;
        pats[4] = 64'hA5A5_0000_0000_5A5A;
        pats[5] = 64'h0000_0001_8000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        rdchk("R1 mask0", 12'h084, 32'hFFFF_FFFF);
        rdchk("R1 mask1", 12'h0A4, 32'hFFFF_FFFF);
        rdchk("R1 swi", 12'h090, 0);
        rdchk("R1 cfg", 12'h1FC, 0);
        rdchk("R1 rev", 12'h000, 32'h21);
        rdchk("R1 status", 12'h014, 1);

        // R11 read-only writes
        wr(12'h014, 0);
        wr(12'h000, 32'hFFFF);
        wr(12'h080, 32'hFFFF);
        wr(12'h098, 32'hFFFF);
        wr(12'h040, 5);
        rdchk("R11 status", 12'h014, 1);
        rdchk("R11 rev", 12'h000, 32'h21);
        rdchk("R11 raw", 12'h080, 0);
        rdchk("R11 code", 12'h040, 0);
        rdchk("R11 mask kept", 12'h084, 32'hFFFF_FFFF);

        // R10 storage registers
        wr(12'h010, 1);  rdchk("R10 autoidle", 12'h010, 1);
        wr(12'h050, 3);  rdchk("R10 idle", 12'h050, 3);
        wr(12'h04C, 1);  rdchk("R10 prot", 12'h04C, 1);

        // R9 global mask held during register tests
        wr(12'h048, 4);  rdchk("R9 gmask read", 12'h048, 4);

        // R3 mask aliases on bank1
        wr(12'h0A4, 32'h0000_FFFF); rdchk("R3 mask write", 12'h0A4, 32'h0000_FFFF);
        wr(12'h0A8, 32'h0000_00F0); rdchk("R3 mask clear", 12'h0A4, 32'h0000_FF0F);
        wr(12'h0AC, 32'hF000_0000); rdchk("R3 mask set", 12'h0A4, 32'hF000_FF0F);
        rdchk("R3 clear alias reads 0", 12'h0A8, 0);
        rdchk("R3 bank0 untouched", 12'h084, 32'hFFFF_FFFF);

        // R2 pending views
        wr(12'h084, 32'hFFFF_FF00);
        @(negedge clk); lines = 64'h108;
        @(negedge clk); @(negedge clk);
        rdchk("R2 raw", 12'h080, 32'h108);
        rdchk("R2 pend norm", 12'h098, 32'h008);
        rdchk("R2 pend fast empty", 12'h09C, 0);
        wr(12'h10C, 1);
        rdchk("R2 routed away", 12'h098, 0);
        rdchk("R2 pend fast", 12'h09C, 32'h008);

        // R4 software bits
        wr(12'h090, 32'h30);
        rdchk("R4 swi read", 12'h090, 32'h30);
        rdchk("R4 swi pend", 12'h098, 32'h30);
        wr(12'h094, 32'h10);
        rdchk("R4 swi clear", 12'h090, 32'h20);
        rdchk("R4 pend after clear", 12'h098, 32'h20);
        wr(12'h090, 32'h08);
        wr(12'h094, 32'h08);
        rdchk("R4 input keeps pending", 12'h09C, 32'h08);
        @(negedge clk); lines = '0;
        @(negedge clk); @(negedge clk);
        rdchk("R4 input gone", 12'h09C, 0);
        wr(12'h094, 32'h20);
        rdchk("R4 all clear", 12'h098, 0);
        chk("R9 gmask blocked irq", 32'(irq), 0);
        chk("R9 gmask blocked fiq", 32'(fiq), 0);

        // R5 line configuration
        wr(12'h19C, 32'h17);
        rdchk("R5 cfg bank1 line7", 12'h19C, 32'h15);
        wr(12'h200, 32'hFF);
        rdchk("R5 past last bank", 12'h200, 0);
        wr(12'h19C, 0);
        wr(12'h10C, 0);

        // open the channels
        wr(12'h084, 0);
        wr(12'h0A4, 0);
        wr(12'h048, 3);

        // R6/R7/R8 one-hot sweep
        for (int i = 0; i < NL; i++) begin
            int c = i % 2;
            logic [31:0] v;
            wr(12'h100 + 12'(4 * i), 32'(c));
            @(negedge clk); lines = '0; lines[i] = 1'b1;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R7 fire line %0d", i), {30'b0, fiq, irq}, c ? 32'd2 : 32'd1);
            rdchk($sformatf("R6 code line %0d", i), c ? 12'h044 : 12'h040, 32'(i));
            rd(12'h080 + 12'((i / 32) * 32) + (c ? 12'h01C : 12'h018), v);
            chk($sformatf("R2 view line %0d", i), v, 32'(1) << (i % 32));
            @(negedge clk); lines = '0;
            @(negedge clk); @(negedge clk);
            chk($sformatf("R7 held line %0d", i), {30'b0, fiq, irq}, c ? 32'd2 : 32'd1);
            rdchk($sformatf("R7 code held %0d", i), c ? 12'h044 : 12'h040, 32'(i));
            wr(12'h048, c ? 32'd2 : 32'd1);
            chk($sformatf("R8 dropped %0d", i), {30'b0, fiq, irq}, 0);
            wr(12'h100 + 12'(4 * i), 0);
        end

        // R6 priority patterns
        for (int sel = 0; sel < 2; sel++) begin
            for (int i = 0; i < NL; i++)
                wr(12'h100 + 12'(4 * i), 32'(prio_map(i, sel) << 2));
            for (int k = 0; k < 6; k++) begin
                @(negedge clk); lines = pats[k];
                @(negedge clk); @(negedge clk);
                chk($sformatf("R6 irq pat %0d/%0d", sel, k), 32'(irq), 1);
                rdchk($sformatf("R6 winner pat %0d/%0d", sel, k), 12'h040,
                      32'(exp_winner(pats[k], sel)));
                @(negedge clk); lines = '0;
                @(negedge clk);
                wr(12'h048, 1);
            end
        end

        // R9 global mask gating, R8 re-arm with source still high
        wr(12'h048, 4);
        @(negedge clk); lines = 64'h1;
        repeat (3) @(negedge clk);
        chk("R9 masked stays low", 32'(irq), 0);
        wr(12'h048, 0);
        chk("R9 one edge after unmask", 32'(irq), 0);
        @(negedge clk);
        chk("R9 fires after unmask", 32'(irq), 1);
        wr(12'h048, 1);
        chk("R8 low after rearm", 32'(irq), 0);
        @(negedge clk);
        chk("R8 refires", 32'(irq), 1);
        @(negedge clk); lines = '0;
        @(negedge clk);
        wr(12'h048, 1);

        // R10 soft reset
        wr(12'h090, 1);
        @(negedge clk);
        chk("R10 swi fired", 32'(irq), 1);
        wr(12'h100, 32'h15);
        wr(12'h010, 2);
        chk("R10 irq cleared", 32'(irq), 0);
        rdchk("R10 mask reset", 12'h084, 32'hFFFF_FFFF);
        rdchk("R10 swi reset", 12'h090, 0);
        rdchk("R10 cfg reset", 12'h100, 0);
        rdchk("R10 autoidle reset", 12'h010, 0);
        rdchk("R10 idle reset", 12'h050, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule